// File: doc/BRIEF.md
# Combo PHY Power Sequencer

This block is the control state machine that powers a combined MIPI / LVDS display PHY up and down in a safe order. It holds no analog circuitry. It drives the individual power-down, reset, mode-select, divider and lane-enable controls that the analog macro samples. A single start-up request runs a bring-up path chosen by the mode input. A shut-down request runs one fixed tear-down path. A ready flag tells the display controller that the lanes are live.

Every step is one clock cycle long. The exception is the timed steps: reset pulses of one microsecond and the long LVDS settling wait. These are measured in microseconds, using a cycles-per-microsecond value supplied as an input. The same netlist therefore works at any control clock frequency. The mode is captured when the start request is accepted. An unsupported mode sends the block straight back to the fully powered-down state and raises an error flag.

Top module: `phy_pwr_seq`

## Requirements
- R1: While reset is asserted, the outputs take these values: `bg_pd`=1, `pwr_work`=2'b10, `ldo_pd`=1, `pll_pd`=1, `mode_sel`=0, `ana_rst`=0, `dig_rst_n`=1, `lane_en`=0, `smp_rev`=0, `lvds_pll_pd`=1, `lvds_bg_pd`=1, `lvds_rst_n`=1, `lvds_dig_en`=0, `lvds_lane_en`=0, `pre_div`=0, `fb_div`=0, `ready`=0, `err`=0.
- R2: The block accepts `up_req` only when fully off. It captures `mode_i` at that point (2'b01 selects MIPI, 2'b10 selects LVDS). Counting the accepting edge as edge 1, `bg_pd` falls at edge 1 and `pwr_work` becomes 2'b01 at edge 2. The block branches on the captured mode after that.
- R3: MIPI bring-up runs in this order, with c the cycles per microsecond:
  - `mode_sel`=3'b001 at edge 4 (bit 2 TTL, bit 1 LVDS, bit 0 MIPI).
  - `pre_div`/`fb_div` load `mipi_prediv`/`mipi_fbdiv` at edge 5.
  - `ldo_pd` and `pll_pd` fall at edge 6.
  - `ana_rst` is high from edge 7 for c cycles.
  - `dig_rst_n` is low from edge 8+c for c cycles.
- R4: In MIPI mode, all bits of `lane_en` (bit 4 clock lane, bits 3..0 data lanes) rise together at edge 9+2c. `ready` rises at edge 10+2c.
- R5: LVDS bring-up runs in this order, with W = `LVDS_WAIT_US` (default 20000):
  - `smp_rev`=1 at edge 4.
  - `mode_sel`=3'b010 at edge 5.
  - `pre_div`=2 and `fb_div`=28 at edge 6.
  - `lvds_pll_pd` and `lvds_bg_pd` fall at edge 7.
  - A wait of W·c cycles follows.
- R6: After the LVDS wait, `lvds_rst_n` is low from edge 8+W·c for c cycles. `lvds_dig_en` rises at edge 9+(W+1)·c. `lvds_lane_en` goes all ones at edge 10+(W+1)·c. `ready` rises at edge 11+(W+1)·c.
- R7: A `cyc_per_us` value of 0 is treated as 1.
- R8: After `down_req` is accepted in the ready state (edge 1), the block steps down in this order:
  - `lane_en` clears at edge 1.
  - `ldo_pd`/`pll_pd` rise at edge 2.
  - `pwr_work` becomes 2'b10 at edge 3.
  - `bg_pd` rises at edge 4.
  - `lvds_lane_en` clears at edge 5.
  - `lvds_dig_en` falls at edge 6.
  - `lvds_pll_pd`/`lvds_bg_pd` rise at edge 7.
  - `ready` falls at edge 1.
- R9: When the captured mode is neither MIPI nor LVDS, the following happens:
  - `err` rises at edge 4.
  - The power-down steps follow (`pwr_work`=2'b10 at edge 6, `bg_pd` high at edge 7).
  - `ready` stays low.
  - `err` holds until the next accepted `up_req`, which clears it.
- R10: A `down_req` seen during bring-up is held. Bring-up completes, `ready` is high for exactly one cycle, and then power-down starts.
- R11: `up_req` is ignored unless the block is off. `down_req` is ignored while the block is off. In both cases no output changes.
- R12: `mode_sel` never has more than one bit set. `pwr_work` is only ever 2'b01 or 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_req | input | 1 | Start-up request |
| down_req | input | 1 | Shut-down request |
| mode_i | input | 2 | 01 MIPI, 10 LVDS, other values invalid |
| cyc_per_us | input | CYC_W | Clock cycles per microsecond |
| mipi_prediv | input | PRE_W | MIPI PLL pre-divider |
| mipi_fbdiv | input | FB_W | MIPI PLL feedback divider |
| bg_pd | output | 1 | Bandgap power-down |
| pwr_work | output | 2 | Power-work code, 01 enable, 10 disable |
| ldo_pd | output | 1 | LDO power-down |
| pll_pd | output | 1 | PLL power-down |
| ana_rst | output | 1 | Synchronous analog reset, active high |
| dig_rst_n | output | 1 | Digital reset, active low |
| mode_sel | output | 3 | One-hot mode select: bit 2 TTL, bit 1 LVDS, bit 0 MIPI |
| pre_div | output | PRE_W | Loaded pre-divider |
| fb_div | output | FB_W | Loaded feedback divider |
| lane_en | output | N_DATA+1 | MIPI lane enables, MSB clock lane |
| smp_rev | output | 1 | Sample clock direction reversed |
| lvds_pll_pd | output | 1 | LVDS PLL power-down |
| lvds_bg_pd | output | 1 | LVDS bandgap power-down |
| lvds_rst_n | output | 1 | LVDS digital reset, active low |
| lvds_dig_en | output | 1 | LVDS digital logic enable |
| lvds_lane_en | output | N_DATA+1 | LVDS lane driver enables, MSB clock lane |
| ready | output | 1 | Bring-up complete, lanes live |
| err | output | 1 | Last start-up aborted on an invalid mode |

## Verification
Every control is a register that changes only on the step that owns it. A state machine that skips, repeats or reorders a step therefore shows up at the ports within the same cycle, as an edge that lands earlier or later than its expected edge number. A timer that miscounts shifts every later edge by whole microseconds. This surfaces as a wrong reset-pulse width or a late ready flag, one microsecond after the fault. A wrong branch or a stale captured mode drives the wrong mode select at edge 4 or 5, or raises the error flag where none belongs.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam logic [1:0] MODE_MIPI = 2'b01;
  localparam logic [1:0] MODE_LVDS = 2'b10;
  localparam logic [1:0] PW_EN     = 2'b01;
  localparam logic [1:0] PW_DIS    = 2'b10;
  localparam logic [2:0] SEL_MIPI  = 3'b001;
  localparam logic [2:0] SEL_LVDS  = 3'b010;

  typedef enum logic [4:0] {
    ST_OFF, ST_BG, ST_PW, ST_BR,
    M_SEL, M_DIV, M_PWR, M_ARST, M_AREL, M_DRST, M_DREL, M_LANE,
    L_DIR, L_SEL, L_DIV, L_PWR, L_WAIT, L_RST, L_REL, L_DEN, L_LANE,
    ST_ON,
    D_LANE, D_PLL, D_PW, D_BG, D_LLN, D_LDEN, D_LPD
  } seq_st_e;

  typedef struct packed {
    logic       bg_pd;
    logic [1:0] pwr_work;
    logic       ldo_pd;
    logic       pll_pd;
    logic [2:0] mode_sel;
    logic       ana_rst;
    logic       dig_rst_n;
    logic       smp_rev;
    logic       lvds_pll_pd;
    logic       lvds_bg_pd;
    logic       lvds_rst_n;
    logic       lvds_dig_en;
    logic       ready;
  } ctl_t;

  localparam ctl_t CTL_OFF = '{bg_pd: 1'b1, pwr_work: PW_DIS, ldo_pd: 1'b1,
                               pll_pd: 1'b1, mode_sel: 3'b000, ana_rst: 1'b0,
                               dig_rst_n: 1'b1, smp_rev: 1'b0, lvds_pll_pd: 1'b1,
                               lvds_bg_pd: 1'b1, lvds_rst_n: 1'b1,
                               lvds_dig_en: 1'b0, ready: 1'b0};

  function automatic logic is_wait(seq_st_e s);
    return (s == M_ARST) || (s == M_DRST) || (s == L_WAIT) || (s == L_RST);
  endfunction

  function automatic logic is_bringup(seq_st_e s);
    return (s != ST_OFF) && (s != ST_ON) && (s < D_LANE);
  endfunction

endpackage

// File: rtl/phy_seq_rst_sync.sv
module phy_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int CYC_W = 16,
  parameter int US_W  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CYC_W-1:0] cyc_per_us,
  input  logic [US_W-1:0]  us_cnt,
  output logic             done
);
  logic [CYC_W-1:0] pre_q, pre_d, cyc_m1;
  logic [US_W-1:0]  us_q, us_d;
  logic             busy_q, busy_d;

  assign cyc_m1 = (cyc_per_us == '0) ? '0 : cyc_per_us - CYC_W'(1);
  assign done   = busy_q && (pre_q == '0) && (us_q == '0);

  always_comb begin
    pre_d  = pre_q;
    us_d   = us_q;
    busy_d = busy_q;
    if (start) begin
      pre_d  = cyc_m1;
      us_d   = us_cnt - US_W'(1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
      end else if (pre_q == '0) begin
        pre_d = cyc_m1;
        us_d  = us_q - US_W'(1);
      end else begin
        pre_d = pre_q - CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      us_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      us_q   <= us_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_seq_pkg::*;
#(
  parameter int US_W         = 15,
  parameter int LVDS_WAIT_US = 20000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_req,
  input  logic            down_req,
  input  logic [1:0]      mode_i,
  input  logic            tmr_done,
  output seq_st_e         state_d,
  output logic            tmr_start,
  output logic [US_W-1:0] tmr_us,
  output logic            err
);
  seq_st_e    state_q;
  logic [1:0] mode_q;
  logic       pend_q, err_q;
  logic       accept;

  assign accept = (state_q == ST_OFF) && up_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF: if (up_req) state_d = ST_BG;
      ST_BG:  state_d = ST_PW;
      ST_PW:  state_d = ST_BR;
      ST_BR:  state_d = (mode_q == MODE_MIPI) ? M_SEL :
                        (mode_q == MODE_LVDS) ? L_DIR : D_LANE;
      M_SEL:  state_d = M_DIV;
      M_DIV:  state_d = M_PWR;
      M_PWR:  state_d = M_ARST;
      M_ARST: if (tmr_done) state_d = M_AREL;
      M_AREL: state_d = M_DRST;
      M_DRST: if (tmr_done) state_d = M_DREL;
      M_DREL: state_d = M_LANE;
      M_LANE: state_d = ST_ON;
      L_DIR:  state_d = L_SEL;
      L_SEL:  state_d = L_DIV;
      L_DIV:  state_d = L_PWR;
      L_PWR:  state_d = L_WAIT;
      L_WAIT: if (tmr_done) state_d = L_RST;
      L_RST:  if (tmr_done) state_d = L_REL;
      L_REL:  state_d = L_DEN;
      L_DEN:  state_d = L_LANE;
      L_LANE: state_d = ST_ON;
      ST_ON:  if (down_req || pend_q) state_d = D_LANE;
      D_LANE: state_d = D_PLL;
      D_PLL:  state_d = D_PW;
      D_PW:   state_d = D_BG;
      D_BG:   state_d = D_LLN;
      D_LLN:  state_d = D_LDEN;
      D_LDEN: state_d = D_LPD;
      D_LPD:  state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  assign tmr_start = (state_d != state_q) && is_wait(state_d);
  assign tmr_us    = (state_d == L_WAIT) ? US_W'(LVDS_WAIT_US) : US_W'(1);
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      mode_q  <= 2'b00;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) mode_q <= mode_i;
      if (state_d == D_LANE)                     pend_q <= 1'b0;
      else if (down_req && is_bringup(state_q))  pend_q <= 1'b1;
      if (accept)                                      err_q <= 1'b0;
      else if (state_q == ST_BR && state_d == D_LANE)  err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/phy_seq_ctl.sv
module phy_seq_ctl
  import phy_seq_pkg::*;
#(
  parameter int PRE_W   = 5,
  parameter int FB_W    = 9,
  parameter int LANE_W  = 5,
  parameter int LVDS_PRE = 2,
  parameter int LVDS_FB  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_e           state_d,
  input  logic [PRE_W-1:0]  mipi_prediv,
  input  logic [FB_W-1:0]   mipi_fbdiv,
  output ctl_t              ctl,
  output logic [PRE_W-1:0]  pre_div,
  output logic [FB_W-1:0]   fb_div,
  output logic [LANE_W-1:0] lane_en,
  output logic [LANE_W-1:0] lvds_lane_en
);
  ctl_t              ctl_q, ctl_d;
  logic [PRE_W-1:0]  pre_q, pre_nx;
  logic [FB_W-1:0]   fb_q, fb_nx;
  logic              div_ld;
  logic [LANE_W-1:0] lane_q, lane_d, llane_q, llane_d;

  always_comb begin
    ctl_d       = ctl_q;
    ctl_d.ready = (state_d == ST_ON);
    lane_d      = lane_q;
    llane_d     = llane_q;
    div_ld      = 1'b0;
    pre_nx      = mipi_prediv;
    fb_nx       = mipi_fbdiv;
    case (state_d)
      ST_BG:  ctl_d.bg_pd    = 1'b0;
      ST_PW:  ctl_d.pwr_work = PW_EN;
      M_SEL:  ctl_d.mode_sel = SEL_MIPI;
      M_DIV:  div_ld = 1'b1;
      M_PWR:  begin ctl_d.ldo_pd = 1'b0; ctl_d.pll_pd = 1'b0; end
      M_ARST: ctl_d.ana_rst   = 1'b1;
      M_AREL: ctl_d.ana_rst   = 1'b0;
      M_DRST: ctl_d.dig_rst_n = 1'b0;
      M_DREL: ctl_d.dig_rst_n = 1'b1;
      M_LANE: lane_d = '1;
      L_DIR:  ctl_d.smp_rev  = 1'b1;
      L_SEL:  ctl_d.mode_sel = SEL_LVDS;
      L_DIV:  begin
        div_ld = 1'b1;
        pre_nx = PRE_W'(LVDS_PRE);
        fb_nx  = FB_W'(LVDS_FB);
      end
      L_PWR:  begin ctl_d.lvds_pll_pd = 1'b0; ctl_d.lvds_bg_pd = 1'b0; end
      L_RST:  ctl_d.lvds_rst_n  = 1'b0;
      L_REL:  ctl_d.lvds_rst_n  = 1'b1;
      L_DEN:  ctl_d.lvds_dig_en = 1'b1;
      L_LANE: llane_d = '1;
      D_LANE: lane_d = '0;
      D_PLL:  begin ctl_d.ldo_pd = 1'b1; ctl_d.pll_pd = 1'b1; end
      D_PW:   ctl_d.pwr_work = PW_DIS;
      D_BG:   ctl_d.bg_pd    = 1'b1;
      D_LLN:  llane_d = '0;
      D_LDEN: ctl_d.lvds_dig_en = 1'b0;
      D_LPD:  begin ctl_d.lvds_pll_pd = 1'b1; ctl_d.lvds_bg_pd = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= CTL_OFF;
      lane_q  <= '0;
      llane_q <= '0;
      pre_q   <= '0;
      fb_q    <= '0;
    end else begin
      ctl_q   <= ctl_d;
      lane_q  <= lane_d;
      llane_q <= llane_d;
      if (div_ld) begin
        pre_q <= pre_nx;
        fb_q  <= fb_nx;
      end
    end
  end

  assign ctl          = ctl_q;
  assign pre_div      = pre_q;
  assign fb_div       = fb_q;
  assign lane_en      = lane_q;
  assign lvds_lane_en = llane_q;
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int CYC_W        = 16,
  parameter int PRE_W        = 5,
  parameter int FB_W         = 9,
  parameter int N_DATA       = 4,
  parameter int LVDS_WAIT_US = 20000,
  parameter int LVDS_PRE     = 2,
  parameter int LVDS_FB      = 28,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic              down_req,
  input  logic [1:0]        mode_i,
  input  logic [CYC_W-1:0]  cyc_per_us,
  input  logic [PRE_W-1:0]  mipi_prediv,
  input  logic [FB_W-1:0]   mipi_fbdiv,
  output logic              bg_pd,
  output logic [1:0]        pwr_work,
  output logic              ldo_pd,
  output logic              pll_pd,
  output logic              ana_rst,
  output logic              dig_rst_n,
  output logic [2:0]        mode_sel,
  output logic [PRE_W-1:0]  pre_div,
  output logic [FB_W-1:0]   fb_div,
  output logic [N_DATA:0]   lane_en,
  output logic              smp_rev,
  output logic              lvds_pll_pd,
  output logic              lvds_bg_pd,
  output logic              lvds_rst_n,
  output logic              lvds_dig_en,
  output logic [N_DATA:0]   lvds_lane_en,
  output logic              ready,
  output logic              err
);
  localparam int LANE_W = N_DATA + 1;
  localparam int US_W   = $clog2(LVDS_WAIT_US + 1);

  logic            srst_n, tmr_start, tmr_done;
  logic [US_W-1:0] tmr_us;
  seq_st_e         state_d;
  ctl_t            ctl;

  phy_seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  phy_seq_timer #(.CYC_W(CYC_W), .US_W(US_W)) u_tmr (
    .clk(clk), .rst_n(srst_n), .start(tmr_start), .cyc_per_us(cyc_per_us),
    .us_cnt(tmr_us), .done(tmr_done));

  phy_seq_fsm #(.US_W(US_W), .LVDS_WAIT_US(LVDS_WAIT_US)) u_fsm (
    .clk(clk), .rst_n(srst_n), .up_req(up_req), .down_req(down_req),
    .mode_i(mode_i), .tmr_done(tmr_done), .state_d(state_d),
    .tmr_start(tmr_start), .tmr_us(tmr_us), .err(err));

  phy_seq_ctl #(.PRE_W(PRE_W), .FB_W(FB_W), .LANE_W(LANE_W),
                .LVDS_PRE(LVDS_PRE), .LVDS_FB(LVDS_FB)) u_ctl (
    .clk(clk), .rst_n(srst_n), .state_d(state_d), .mipi_prediv(mipi_prediv),
    .mipi_fbdiv(mipi_fbdiv), .ctl(ctl), .pre_div(pre_div), .fb_div(fb_div),
    .lane_en(lane_en), .lvds_lane_en(lvds_lane_en));

  assign bg_pd       = ctl.bg_pd;
  assign pwr_work    = ctl.pwr_work;
  assign ldo_pd      = ctl.ldo_pd;
  assign pll_pd      = ctl.pll_pd;
  assign ana_rst     = ctl.ana_rst;
  assign dig_rst_n   = ctl.dig_rst_n;
  assign mode_sel    = ctl.mode_sel;
  assign smp_rev     = ctl.smp_rev;
  assign lvds_pll_pd = ctl.lvds_pll_pd;
  assign lvds_bg_pd  = ctl.lvds_bg_pd;
  assign lvds_rst_n  = ctl.lvds_rst_n;
  assign lvds_dig_en = ctl.lvds_dig_en;
  assign ready       = ctl.ready;
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk #(
  parameter int LANE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              err,
  input logic              bg_pd,
  input logic [1:0]        pwr_work,
  input logic              ldo_pd,
  input logic              pll_pd,
  input logic [2:0]        mode_sel,
  input logic              ana_rst,
  input logic              dig_rst_n,
  input logic [LANE_W-1:0] lane_en,
  input logic              lvds_pll_pd,
  input logic              lvds_bg_pd,
  input logic              lvds_rst_n,
  input logic              lvds_dig_en,
  input logic [LANE_W-1:0] lvds_lane_en
);
  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_sel));                                              // R12
  AST_PW_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_work == 2'b01) || (pwr_work == 2'b10));                      // R12
  AST_PW_NEEDS_BG: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_work == 2'b01) |-> !bg_pd);                                  // R2
  AST_DRST_AFTER_ARST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dig_rst_n) |-> (!ana_rst && !pll_pd && !ldo_pd));            // R3
  AST_MIPI_LANES_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en != '0) |-> (dig_rst_n && !ana_rst && !pll_pd && !bg_pd)); // R4
  AST_LVDS_LANES_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvds_lane_en != '0) |-> (lvds_dig_en && lvds_rst_n && !lvds_pll_pd && !lvds_bg_pd)); // R6
  AST_READY_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ((&lane_en) || (&lvds_lane_en)));                       // R4
  AST_BG_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_pd) |-> (lane_en == '0 && ldo_pd && pll_pd && pwr_work == 2'b10)); // R8
  AST_ERR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !ready);                                                  // R9
endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(.LANE_W(N_DATA + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .err(err), .bg_pd(bg_pd),
  .pwr_work(pwr_work), .ldo_pd(ldo_pd), .pll_pd(pll_pd), .mode_sel(mode_sel),
  .ana_rst(ana_rst), .dig_rst_n(dig_rst_n), .lane_en(lane_en),
  .lvds_pll_pd(lvds_pll_pd), .lvds_bg_pd(lvds_bg_pd), .lvds_rst_n(lvds_rst_n),
  .lvds_dig_en(lvds_dig_en), .lvds_lane_en(lvds_lane_en));

// File: tb/sim_phy_pwr_seq.sv
module sim_phy_pwr_seq;
  localparam int W = 20000;

  logic clk = 1'b0;
  logic rst_n, up_req, down_req;
  logic [1:0] mode_i;
  logic [15:0] cyc_per_us;
  logic [4:0] mipi_prediv, pre_div;
  logic [8:0] mipi_fbdiv, fb_div;
  logic bg_pd, ldo_pd, pll_pd, ana_rst, dig_rst_n, smp_rev;
  logic lvds_pll_pd, lvds_bg_pd, lvds_rst_n, lvds_dig_en, ready, err;
  logic [1:0] pwr_work;
  logic [2:0] mode_sel;
  logic [4:0] lane_en, lvds_lane_en;

  int n_chk = 0, n_fail = 0, tcnt = 0;
  int t_bg, t_bgoff, t_pw, t_pwdis, t_ldo, t_plloff, t_arst_r, t_arst_f;
  int t_drst_f, t_drst_r, t_lane, t_laneoff, t_lpwr, t_lpd, t_lrst_f, t_lrst_r;
  int t_den, t_denoff, t_llane, t_llaneoff, t_ready, t_err;
  logic p_bg, p_pll, p_arst, p_drst, p_lpd, p_lrst, p_den, p_rdy, p_err;
  logic [1:0] p_pw;
  logic [4:0] p_lane, p_llane;

  always #10 clk = ~clk;

  phy_pwr_seq u0 (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
    .mode_i(mode_i), .cyc_per_us(cyc_per_us), .mipi_prediv(mipi_prediv),
    .mipi_fbdiv(mipi_fbdiv), .bg_pd(bg_pd), .pwr_work(pwr_work),
    .ldo_pd(ldo_pd), .pll_pd(pll_pd), .ana_rst(ana_rst), .dig_rst_n(dig_rst_n),
    .mode_sel(mode_sel), .pre_div(pre_div), .fb_div(fb_div), .lane_en(lane_en),
    .smp_rev(smp_rev), .lvds_pll_pd(lvds_pll_pd), .lvds_bg_pd(lvds_bg_pd),
    .lvds_rst_n(lvds_rst_n), .lvds_dig_en(lvds_dig_en),
    .lvds_lane_en(lvds_lane_en), .ready(ready), .err(err));

  // {mode, cyc_per_us, prediv, fbdiv}
  localparam logic [19:0] VEC [7] = '{
    {2'b01, 4'd1, 5'd3,  9'd100},
    {2'b10, 4'd1, 5'd9,  9'd77},
    {2'b01, 4'd0, 5'd1,  9'd12},
    {2'b00, 4'd1, 5'd4,  9'd40},
    {2'b10, 4'd2, 5'd6,  9'd200},
    {2'b01, 4'd4, 5'd31, 9'd511},
    {2'b11, 4'd1, 5'd5,  9'd50}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    p_bg = bg_pd; p_pw = pwr_work; p_pll = pll_pd; p_arst = ana_rst;
    p_drst = dig_rst_n; p_lane = lane_en; p_lpd = lvds_pll_pd;
    p_lrst = lvds_rst_n; p_den = lvds_dig_en; p_llane = lvds_lane_en;
    p_rdy = ready; p_err = err;
  endtask

  task automatic clear();
    tcnt = 0;
    t_bg = -1; t_bgoff = -1; t_pw = -1; t_pwdis = -1; t_ldo = -1; t_plloff = -1;
    t_arst_r = -1; t_arst_f = -1; t_drst_f = -1; t_drst_r = -1; t_lane = -1;
    t_laneoff = -1; t_lpwr = -1; t_lpd = -1; t_lrst_f = -1; t_lrst_r = -1;
    t_den = -1; t_denoff = -1; t_llane = -1; t_llaneoff = -1; t_ready = -1;
    t_err = -1;
    snap();
  endtask

  always @(negedge clk) begin
    tcnt++;
    if (bg_pd != p_bg) begin
      if (!bg_pd && t_bg < 0) t_bg = tcnt;
      if (bg_pd && t_bgoff < 0) t_bgoff = tcnt;
    end
    if (pwr_work != p_pw) begin
      if (pwr_work == 2'b01 && t_pw < 0) t_pw = tcnt;
      if (pwr_work == 2'b10 && t_pwdis < 0) t_pwdis = tcnt;
    end
    if (pll_pd != p_pll) begin
      if (!pll_pd && t_ldo < 0) t_ldo = tcnt;
      if (pll_pd && t_plloff < 0) t_plloff = tcnt;
    end
    if (ana_rst && !p_arst && t_arst_r < 0) t_arst_r = tcnt;
    if (!ana_rst && p_arst && t_arst_f < 0) t_arst_f = tcnt;
    if (!dig_rst_n && p_drst && t_drst_f < 0) t_drst_f = tcnt;
    if (dig_rst_n && !p_drst && t_drst_r < 0) t_drst_r = tcnt;
    if (lane_en != p_lane) begin
      if (lane_en != 0 && t_lane < 0) t_lane = tcnt;
      if (lane_en == 0 && t_laneoff < 0) t_laneoff = tcnt;
    end
    if (lvds_pll_pd != p_lpd) begin
      if (!lvds_pll_pd && t_lpwr < 0) t_lpwr = tcnt;
      if (lvds_pll_pd && t_lpd < 0) t_lpd = tcnt;
    end
    if (!lvds_rst_n && p_lrst && t_lrst_f < 0) t_lrst_f = tcnt;
    if (lvds_rst_n && !p_lrst && t_lrst_r < 0) t_lrst_r = tcnt;
    if (lvds_dig_en && !p_den && t_den < 0) t_den = tcnt;
    if (!lvds_dig_en && p_den && t_denoff < 0) t_denoff = tcnt;
    if (lvds_lane_en != p_llane) begin
      if (lvds_lane_en != 0 && t_llane < 0) t_llane = tcnt;
      if (lvds_lane_en == 0 && t_llaneoff < 0) t_llaneoff = tcnt;
    end
    if (ready && !p_rdy && t_ready < 0) t_ready = tcnt;
    if (err && !p_err && t_err < 0) t_err = tcnt;
    snap();
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check_off(input string tag);
    chk({tag, " bg_pd"}, bg_pd, 1);
    chk({tag, " pwr_work"}, pwr_work, 2);
    chk({tag, " ldo/pll"}, {ldo_pd, pll_pd}, 3);
    chk({tag, " lanes"}, {lane_en, lvds_lane_en}, 0);
    chk({tag, " lvds pd"}, {lvds_pll_pd, lvds_bg_pd, lvds_dig_en}, 3'b110);
    chk({tag, " ready"}, ready, 0);
  endtask

  task automatic do_up(input logic [1:0] md, input int c, input int pr,
                       input int fb, input int limit);
    mode_i = md; cyc_per_us = 16'(c); mipi_prediv = 5'(pr); mipi_fbdiv = 9'(fb);
    clear();
    up_req = 1'b1;
    tick();
    up_req = 1'b0;
    mode_i = ~md;   // captured mode must not follow later changes
    while (!ready && tcnt < limit) tick();
  endtask

  task automatic do_down();
    clear();
    down_req = 1'b1;
    tick();
    down_req = 1'b0;
    repeat (10) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up_req = 1'b0; down_req = 1'b0; mode_i = 2'b01;
    cyc_per_us = 16'd1; mipi_prediv = '0; mipi_fbdiv = '0;
    repeat (3) tick();
    // R1: reset values
    check_off("R1");
    chk("R1 pwr_work", pwr_work, 2);
    chk("R1 mode_sel/smp_rev", {mode_sel, smp_rev}, 0);
    chk("R1 resets", {ana_rst, dig_rst_n, lvds_rst_n}, 3'b011);
    chk("R1 dividers", {pre_div, fb_div}, 0);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    repeat (4) tick();

    for (int i = 0; i < 7; i++) begin
      logic [19:0] v;
      int c, ce;
      v  = VEC[i];
      c  = int'(v[17:14]);
      ce = (c == 0) ? 1 : c;
      do_up(v[19:18], c, int'(v[13:9]), int'(v[8:0]),
            (v[19:18] == 2'b10) ? 40 + (W + 1) * ce : 40);
      chk("R2 bandgap on edge", t_bg, 1);
      chk("R2 power-work enable edge", t_pw, 2);
      if (v[19:18] == 2'b01) begin
        chk((c == 0) ? "R7 R3 mode_sel" : "R3 mode_sel", mode_sel, 1);
        chk("R3 pre_div", pre_div, int'(v[13:9]));
        chk("R3 fb_div", fb_div, int'(v[8:0]));
        chk("R3 ldo/pll on edge", t_ldo, 6);
        chk("R3 analog reset rise", t_arst_r, 7);
        chk((c == 0) ? "R7 analog reset width" : "R3 analog reset fall", t_arst_f, 7 + ce);
        chk("R3 digital reset fall", t_drst_f, 8 + ce);
        chk("R3 digital reset rise", t_drst_r, 8 + 2 * ce);
        chk("R4 lanes edge", t_lane, 9 + 2 * ce);
        chk("R4 lanes all on", lane_en, 31);
        chk("R4 ready edge", t_ready, 10 + 2 * ce);
        chk("R9 err cleared", err, 0);
      end else if (v[19:18] == 2'b10) begin
        chk("R5 smp_rev", smp_rev, 1);
        chk("R5 mode_sel", mode_sel, 2);
        chk("R5 fixed dividers", {pre_div, fb_div}, {5'd2, 9'd28});
        chk("R5 lvds power on edge", t_lpwr, 7);
        chk("R5 wait then reset", t_lrst_f, 8 + W * ce);
        chk("R6 lvds reset release", t_lrst_r, 8 + W * ce + ce);
        chk("R6 digital enable", t_den, 9 + (W + 1) * ce);
        chk("R6 lane drivers", t_llane, 10 + (W + 1) * ce);
        chk("R6 lane drivers all on", lvds_lane_en, 31);
        chk("R6 ready edge", t_ready, 11 + (W + 1) * ce);
        chk("R9 err cleared", err, 0);
      end else begin
        chk("R9 err edge", t_err, 4);
        chk("R9 power-work disabled edge", t_pwdis, 6);
        chk("R9 bandgap off edge", t_bgoff, 7);
        chk("R9 err held", err, 1);
        chk("R9 never ready", t_ready, -1);
        check_off("R9");
      end
      chk("R12 mode_sel onehot", $countones(mode_sel) <= 1, 1);
      if (v[19:18] == 2'b01 || v[19:18] == 2'b10) begin
        do_down();
        if (v[19:18] == 2'b01) begin
          chk("R8 lanes off edge", t_laneoff, 1);
          chk("R8 ldo/pll off edge", t_plloff, 2);
        end else begin
          chk("R8 lvds lanes off edge", t_llaneoff, 5);
          chk("R8 lvds digital off edge", t_denoff, 6);
          chk("R8 lvds power off edge", t_lpd, 7);
        end
        chk("R8 power-work off edge", t_pwdis, 3);
        chk("R8 bandgap off edge", t_bgoff, 4);
        check_off("R8");
      end
    end

    // R11: down request while off has no effect
    clear();
    down_req = 1'b1; tick(); down_req = 1'b0;
    repeat (8) tick();
    chk("R11 down ignored when off", t_bg + t_pw + t_ready, -3);
    check_off("R11");

    // R10: down request during bring-up is held
    mode_i = 2'b01; cyc_per_us = 16'd1; mipi_prediv = 5'd2; mipi_fbdiv = 9'd60;
    clear();
    up_req = 1'b1; tick(); up_req = 1'b0;
    tick(); tick();
    down_req = 1'b1; tick(); down_req = 1'b0;
    while (!ready && tcnt < 40) tick();
    chk("R10 ready still reached", t_ready, 12);
    tick();
    chk("R10 ready one cycle", ready, 0);
    chk("R10 lanes off after ready", lane_en, 0);
    repeat (8) tick();
    check_off("R10");

    // R11: start request while on has no effect
    do_up(2'b01, 1, 7, 99, 40);
    clear();
    up_req = 1'b1; repeat (3) tick(); up_req = 1'b0;
    repeat (3) tick();
    chk("R11 up ignored when on", ready, 1);
    chk("R11 no step re-run", t_bg + t_arst_r + t_drst_f, -3);
    chk("R11 dividers kept", {pre_div, fb_div}, {5'd7, 9'd99});
    do_down();

    // R1: asynchronous reset in the middle of a bring-up
    do_up(2'b10, 1, 0, 0, 30);
    rst_n = 1'b0; #2;
    check_off("R1 mid-run");
    chk("R1 mid-run mode_sel", mode_sel, 0);
    rst_n = 1'b1;
    repeat (4) tick();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule